// File: doc/BRIEF.md
# Staged Image Update Doorbell Sequencer

This block is the device side of a staged image update. A host reaches it through a simple register port and sees a 32-bit doorbell word and, four bytes above it, an authentication-result word. The host owns two fields of the doorbell: a one-bit request and a four-bit command nibble. The device owns the other two: a four-bit phase field and an eight-bit outcome byte. Every phase of an update is signalled only through these fields.

A host starts an update by setting the request bit while its command nibble is idle. The sequencer then erases the staging area and waits in the ready phase while the host loads the image. It then either authenticates and copies the image on a write-done command or cancels on an abort command. Erase, authentication and copy are done by external engines. The sequencer starts each engine with a one-cycle go pulse and waits for a one-cycle done strobe that carries the result.

Top module: `upd_doorbell_seq`

## Requirements
- R1: After reset the doorbell word and the authentication-result word both read 0, and the three engine go outputs are low.
- R2: The doorbell word has these fields: request at bit 0, phase at bits 7:4, host command at bits 11:8 and outcome byte at bits 23:16. All other bits read 0. The authentication-result word sits at the doorbell offset plus 4. Phase codes are 0 idle, 1 erasing, 3 ready, 4 authenticating, 5 copying, 6 cancelling and 8 finished. No other code ever appears.
- R3: A host write changes only the request bit and the host command nibble. Bits written into the phase or outcome fields are ignored, and writes to the authentication-result word are ignored.
- R4: When the request bit is set with host command 0 while the phase is 0 or 8, the next cycle shows phase 1, a cleared request bit, outcome 0x00 and a one-cycle erase_go pulse.
- R5: A request that cannot start is discarded the cycle after it is seen: the request bit reads 0 and the phase is unchanged. A request cannot start when the phase is busy (not 0 or 8) or when the host command is nonzero.
- R6: On erase done in phase 1, the block handles three cases. If erase_fail is set, the phase returns to 0 with outcome 0x07; erase_fail wins over wearout. If only erase_wearout is set, the phase returns to 0 with outcome 0x08. Otherwise the phase moves to 3 and the host command nibble is cleared.
- R7: In phase 3, host command 1 moves the phase to 4 with a one-cycle auth_go pulse. Host commands given in any other phase are not acted on, and a command written during phase 1 is cleared on entry to phase 3.
- R8: In phase 3, host command 2 moves the phase to 6 for one cycle. The phase then returns to 0 with the host command cleared and outcome 0x00.
- R9: On a passing authentication the phase moves to 5 with a one-cycle copy_go pulse. On copy done, copy_ok gives phase 8 with outcome 0x00; otherwise the phase returns to 0 with outcome 0x03. Either way the host command is cleared.
- R10: On a failing authentication the phase returns to 0 with outcome 0x02 and the host command cleared. The authentication-result word takes auth_code, or 1 if auth_code is 0.
- R11: The authentication-result word is cleared to 0 when an update starts and when authentication passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | AW | Host byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| erase_go | output | 1 | One-cycle start pulse to the erase engine |
| erase_done | input | 1 | Erase finished strobe |
| erase_fail | input | 1 | Erase failed, qualified by erase_done |
| erase_wearout | input | 1 | Excessive write cycles, qualified by erase_done |
| auth_go | output | 1 | One-cycle start pulse to the authentication engine |
| auth_done | input | 1 | Authentication finished strobe |
| auth_pass | input | 1 | Image authentic, qualified by auth_done |
| auth_code | input | 32 | Failure detail, qualified by auth_done |
| copy_go | output | 1 | One-cycle start pulse to the copy engine |
| copy_done | input | 1 | Copy finished strobe |
| copy_ok | input | 1 | Copy succeeded, qualified by copy_done |

## Verification
The assertions take three things as given. Each engine raises its done strobe only while the sequencer sits in that engine's phase. The done strobes are single-cycle. The host does not write the doorbell in the same cycle that the sequencer leaves the cancelling phase. The stimulus follows these rules: it raises each done strobe for exactly one cycle, some cycles after the matching go pulse, and it issues doorbell writes only at points where the sequencer is waiting. Random values are still placed in device-owned bits and in the engine result flags.

// File: rtl/upd_seq_pkg.sv
package upd_seq_pkg;

    typedef enum logic [3:0] {
        PG_IDLE    = 4'd0,
        PG_PREP    = 4'd1,
        PG_READY   = 4'd3,
        PG_AUTH    = 4'd4,
        PG_COPY    = 4'd5,
        PG_CANCEL  = 4'd6,
        PG_KEYHASH = 4'd7,
        PG_DONE    = 4'd8,
        PG_AUXLOAD = 4'd9
    } phase_e;

    localparam logic [3:0] HC_IDLE  = 4'd0;
    localparam logic [3:0] HC_WDONE = 4'd1;
    localparam logic [3:0] HC_ABORT = 4'd2;

    localparam logic [7:0] OC_OK        = 8'h00;
    localparam logic [7:0] OC_TIMEOUT   = 8'h01;
    localparam logic [7:0] OC_AUTHFAIL  = 8'h02;
    localparam logic [7:0] OC_COPYFAIL  = 8'h03;
    localparam logic [7:0] OC_ERASEFAIL = 8'h07;
    localparam logic [7:0] OC_WEAROUT   = 8'h08;

    localparam int REQ_POS = 0;
    localparam int PH_LSB  = 4;
    localparam int HC_LSB  = 8;
    localparam int OC_LSB  = 16;
    localparam int WORD_W  = 32;

    typedef struct packed {
        phase_e              phase;
        logic [7:0]          outcome;
        logic                req;
        logic [3:0]          hcmd;
        logic [WORD_W-1:0]   auth_res;
        logic                erase_go;
        logic                auth_go;
        logic                copy_go;
    } seq_state_t;

endpackage

// File: rtl/upd_reg_decode.sv
module upd_reg_decode
    import upd_seq_pkg::*;
#(
    parameter int             AW     = 8,
    parameter logic [AW-1:0]  DB_OFF = '0
) (
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    input  phase_e              phase,
    input  logic [7:0]          outcome,
    input  logic                req,
    input  logic [3:0]          hcmd,
    input  logic [WORD_W-1:0]   auth_res,
    output logic                db_we,
    output logic                wr_req,
    output logic [3:0]          wr_hcmd,
    output logic [WORD_W-1:0]   reg_rdata
);
    localparam logic [AW-1:0] AR_OFF = AW'(32'(DB_OFF) + 32'd4);

    logic sel_db;
    logic sel_ar;
    logic unused_wbits;

    assign sel_db = (reg_addr == DB_OFF);
    assign sel_ar = (reg_addr == AR_OFF);

    assign db_we   = reg_we && sel_db;
    assign wr_req  = reg_wdata[REQ_POS];
    assign wr_hcmd = reg_wdata[HC_LSB +: 4];

    assign unused_wbits = ^{reg_wdata[WORD_W-1:HC_LSB+4], reg_wdata[HC_LSB-1:REQ_POS+1]};

    always_comb begin
        reg_rdata = '0;
        if (sel_db) begin
            reg_rdata[REQ_POS]        = req;
            reg_rdata[PH_LSB +: 4]    = phase;
            reg_rdata[HC_LSB +: 4]    = hcmd;
            reg_rdata[OC_LSB +: 8]    = outcome;
        end else if (sel_ar) begin
            reg_rdata = auth_res;
        end
    end

endmodule

// File: rtl/upd_phase_ctrl.sv
module upd_phase_ctrl
    import upd_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                db_we,
    input  logic                wr_req,
    input  logic [3:0]          wr_hcmd,
    input  logic                erase_done,
    input  logic                erase_fail,
    input  logic                erase_wearout,
    input  logic                auth_done,
    input  logic                auth_pass,
    input  logic [WORD_W-1:0]   auth_code,
    input  logic                copy_done,
    input  logic                copy_ok,
    output seq_state_t          st
);
    seq_state_t st_d, st_q;
    logic       clr_hcmd;

    always_comb begin
        st_d          = st_q;
        st_d.erase_go = 1'b0;
        st_d.auth_go  = 1'b0;
        st_d.copy_go  = 1'b0;
        clr_hcmd      = 1'b0;

        case (st_q.phase)
            PG_IDLE, PG_DONE: begin
                if (st_q.req && st_q.hcmd == HC_IDLE) begin
                    st_d.phase    = PG_PREP;
                    st_d.outcome  = OC_OK;
                    st_d.auth_res = '0;
                    st_d.erase_go = 1'b1;
                end
            end
            PG_PREP: begin
                if (erase_done) begin
                    clr_hcmd = 1'b1;
                    if (erase_fail) begin
                        st_d.phase   = PG_IDLE;
                        st_d.outcome = OC_ERASEFAIL;
                    end else if (erase_wearout) begin
                        st_d.phase   = PG_IDLE;
                        st_d.outcome = OC_WEAROUT;
                    end else begin
                        st_d.phase   = PG_READY;
                    end
                end
            end
            PG_READY: begin
                if (st_q.hcmd == HC_WDONE) begin
                    st_d.phase   = PG_AUTH;
                    st_d.auth_go = 1'b1;
                end else if (st_q.hcmd == HC_ABORT) begin
                    st_d.phase   = PG_CANCEL;
                end
            end
            PG_AUTH: begin
                if (auth_done) begin
                    if (auth_pass) begin
                        st_d.phase    = PG_COPY;
                        st_d.copy_go  = 1'b1;
                        st_d.auth_res = '0;
                    end else begin
                        clr_hcmd      = 1'b1;
                        st_d.phase    = PG_IDLE;
                        st_d.outcome  = OC_AUTHFAIL;
                        st_d.auth_res = (auth_code == '0) ? WORD_W'(1) : auth_code;
                    end
                end
            end
            PG_COPY: begin
                if (copy_done) begin
                    clr_hcmd = 1'b1;
                    if (copy_ok) begin
                        st_d.phase   = PG_DONE;
                        st_d.outcome = OC_OK;
                    end else begin
                        st_d.phase   = PG_IDLE;
                        st_d.outcome = OC_COPYFAIL;
                    end
                end
            end
            PG_CANCEL: begin
                clr_hcmd     = 1'b1;
                st_d.phase   = PG_IDLE;
                st_d.outcome = OC_OK;
            end
            default: begin
                clr_hcmd   = 1'b1;
                st_d.phase = PG_IDLE;
            end
        endcase

        // Host-owned fields: a host write in this cycle takes precedence.
        if (db_we) begin
            st_d.req  = wr_req;
            st_d.hcmd = wr_hcmd;
        end else begin
            st_d.req  = 1'b0;
            if (clr_hcmd) begin
                st_d.hcmd = HC_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PG_IDLE, outcome: OC_OK, req: 1'b0, hcmd: HC_IDLE,
                      auth_res: '0, erase_go: 1'b0, auth_go: 1'b0, copy_go: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase inside {PG_IDLE, PG_PREP, PG_READY, PG_AUTH, PG_COPY, PG_CANCEL, PG_DONE});

    p_start_from_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.erase_go |-> (st_q.phase == PG_PREP && $past(st_q.phase) inside {PG_IDLE, PG_DONE}));

    p_req_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !db_we) |=> !st_q.req);

    p_erase_exits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PG_PREP && erase_done) |=> st_q.phase inside {PG_IDLE, PG_READY});

    p_auth_from_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.auth_go |-> (st_q.phase == PG_AUTH && $past(st_q.phase) == PG_READY));

    p_cancel_from_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == PG_CANCEL |-> $past(st_q.phase) == PG_READY);

    p_cancel_returns_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PG_CANCEL && !db_we) |=> (st_q.phase == PG_IDLE && st_q.hcmd == HC_IDLE));

    p_authfail_report_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PG_AUTH && auth_done && !auth_pass) |=>
            (st_q.phase == PG_IDLE && st_q.outcome == OC_AUTHFAIL && st_q.auth_res != '0));

    p_copy_go_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.copy_go |=> !st_q.copy_go);

endmodule

// File: rtl/upd_doorbell_seq.sv
module upd_doorbell_seq
    import upd_seq_pkg::*;
#(
    parameter int             AW     = 8,
    parameter logic [AW-1:0]  DB_OFF = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               erase_go,
    input  logic               erase_done,
    input  logic               erase_fail,
    input  logic               erase_wearout,
    output logic               auth_go,
    input  logic               auth_done,
    input  logic               auth_pass,
    input  logic [31:0]        auth_code,
    output logic               copy_go,
    input  logic               copy_done,
    input  logic               copy_ok
);
    seq_state_t st;
    logic       db_we;
    logic       wr_req;
    logic [3:0] wr_hcmd;

    upd_reg_decode #(.AW(AW), .DB_OFF(DB_OFF)) u_decode (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .phase     (st.phase),
        .outcome   (st.outcome),
        .req       (st.req),
        .hcmd      (st.hcmd),
        .auth_res  (st.auth_res),
        .db_we     (db_we),
        .wr_req    (wr_req),
        .wr_hcmd   (wr_hcmd),
        .reg_rdata (reg_rdata)
    );

    upd_phase_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .db_we         (db_we),
        .wr_req        (wr_req),
        .wr_hcmd       (wr_hcmd),
        .erase_done    (erase_done),
        .erase_fail    (erase_fail),
        .erase_wearout (erase_wearout),
        .auth_done     (auth_done),
        .auth_pass     (auth_pass),
        .auth_code     (auth_code),
        .copy_done     (copy_done),
        .copy_ok       (copy_ok),
        .st            (st)
    );

    assign erase_go = st.erase_go;
    assign auth_go  = st.auth_go;
    assign copy_go  = st.copy_go;

endmodule

// File: tb/upd_doorbell_seq_test.sv
module upd_doorbell_seq_test;

    localparam logic [7:0] DB = 8'h00;
    localparam logic [7:0] AR = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        erase_go, erase_done, erase_fail, erase_wearout;
    logic        auth_go, auth_done, auth_pass;
    logic [31:0] auth_code;
    logic        copy_go, copy_done, copy_ok;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    upd_doorbell_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .erase_go(erase_go), .erase_done(erase_done), .erase_fail(erase_fail),
        .erase_wearout(erase_wearout), .auth_go(auth_go), .auth_done(auth_done),
        .auth_pass(auth_pass), .auth_code(auth_code), .copy_go(copy_go),
        .copy_done(copy_done), .copy_ok(copy_ok)
    );

    function automatic logic [31:0] dbw(logic [7:0] oc, logic [3:0] hc, logic [3:0] ph, logic rq);
        return {8'h00, oc, 4'h0, hc, ph, 3'b000, rq};
    endfunction

    function automatic logic [31:0] exp_ares(logic [31:0] code);
        return (code == 32'd0) ? 32'd1 : code;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = DB; reg_wdata = 32'd0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = DB;
        #1;
    endtask

    task automatic chk_db(string tag, logic [31:0] exp);
        logic [31:0] d;
        rd(DB, d);
        chk(tag, d, exp);
    endtask

    task automatic chk_ar(string tag, logic [31:0] exp);
        logic [31:0] d;
        rd(AR, d);
        chk(tag, d, exp);
    endtask

    // Start an update from rest; junk goes into device-owned bits.
    task automatic start_upd();
        wr(DB, {8'h00, 8'($urandom), 4'h0, 4'($urandom), 3'($urandom), 1'b1});
        step();
        chk_db("R4 start phase", dbw(8'h00, 4'h0, 4'd1, 1'b0));
        chk("R4 erase_go", {31'd0, erase_go}, 32'd1);
        chk_ar("R11 ares cleared on start", 32'd0);
        step();
        chk("R4 erase_go single", {31'd0, erase_go}, 32'd0);
    endtask

    task automatic erase_phase(bit ef, bit ew, output bit ready);
        erase_done = 1'b1; erase_fail = ef; erase_wearout = ew;
        step();
        erase_done = 1'b0; erase_fail = 1'b0; erase_wearout = 1'b0;
        ready = !(ef || ew);
        if (ef)      chk_db("R6 erase fail", dbw(8'h07, 4'h0, 4'd0, 1'b0));
        else if (ew) chk_db("R6 wearout", dbw(8'h08, 4'h0, 4'd0, 1'b0));
        else         chk_db("R6 ready", dbw(8'h00, 4'h0, 4'd3, 1'b0));
    endtask

    task automatic auth_copy(bit ap, logic [31:0] code, bit cp);
        wr(DB, 32'h0000_0100 | {8'h00, 8'($urandom), 8'h00, 4'($urandom), 4'h0});
        step();
        chk_db("R7 auth phase", dbw(8'h00, 4'h1, 4'd4, 1'b0));
        chk("R7 auth_go", {31'd0, auth_go}, 32'd1);
        step();
        auth_done = 1'b1; auth_pass = ap; auth_code = code;
        step();
        auth_done = 1'b0; auth_pass = 1'b0; auth_code = 32'd0;
        if (!ap) begin
            chk_db("R10 auth fail", dbw(8'h02, 4'h0, 4'd0, 1'b0));
            chk_ar("R10 auth result", exp_ares(code));
            return;
        end
        chk_db("R9 copy phase", dbw(8'h00, 4'h1, 4'd5, 1'b0));
        chk("R9 copy_go", {31'd0, copy_go}, 32'd1);
        chk_ar("R11 ares cleared on pass", 32'd0);
        step();
        copy_done = 1'b1; copy_ok = cp;
        step();
        copy_done = 1'b0; copy_ok = 1'b0;
        if (cp) chk_db("R9 copy ok", dbw(8'h00, 4'h0, 4'd8, 1'b0));
        else    chk_db("R9 copy fail", dbw(8'h03, 4'h0, 4'd0, 1'b0));
    endtask

    task automatic abort_flow();
        wr(DB, 32'h0000_0200);
        step();
        chk_db("R8 cancel phase", dbw(8'h00, 4'h2, 4'd6, 1'b0));
        step();
        chk_db("R8 cancel return", dbw(8'h00, 4'h0, 4'd0, 1'b0));
    endtask

    task automatic run_flow(bit ef, bit ew, bit ab, bit ap, logic [31:0] code, bit cp);
        bit rdy;
        start_upd();
        repeat (1 + ($urandom % 3)) step();
        erase_phase(ef, ew, rdy);
        if (!rdy) return;
        if (ab) abort_flow();
        else    auth_copy(ap, code, cp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit rdy;
        logic [31:0] d;
        void'($urandom(32'd24681));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = DB; reg_wdata = 32'd0;
        erase_done = 1'b0; erase_fail = 1'b0; erase_wearout = 1'b0;
        auth_done = 1'b0; auth_pass = 1'b0; auth_code = 32'd0;
        copy_done = 1'b0; copy_ok = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk_db("R1 doorbell reset", 32'd0);
        chk_ar("R1 ares reset", 32'd0);
        chk("R1 go outputs", {29'd0, erase_go, auth_go, copy_go}, 32'd0);

        // R3 device-owned fields and auth word are not host-writable
        wr(DB, 32'hFFFF_F0F0);
        chk_db("R3 device fields ignored", 32'd0);
        wr(AR, 32'hDEAD_BEEF);
        chk_ar("R3 ares write ignored", 32'd0);

        // R2 host command nibble at bits 11:8, no effect while idle
        wr(DB, 32'h0000_0500);
        step();
        chk_db("R2 hcmd field", 32'h0000_0500);
        // R5 request with nonzero command is discarded
        wr(DB, 32'h0000_0501);
        step();
        chk_db("R5 request with command dropped", 32'h0000_0500);
        wr(DB, 32'd0);

        // Full success, then a second update starting from phase 8 (R4)
        run_flow(1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b1);
        run_flow(1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b1);

        // R5 busy discard and R7 command in erasing phase dropped
        start_upd();
        wr(DB, 32'h0000_0001);
        step();
        chk_db("R5 busy request discarded", dbw(8'h00, 4'h0, 4'd1, 1'b0));
        wr(DB, 32'h0000_0200);
        erase_phase(1'b0, 1'b0, rdy);
        step();
        chk_db("R7 early abort dropped", dbw(8'h00, 4'h0, 4'd3, 1'b0));
        // R7 abort during authentication not acted on
        wr(DB, 32'h0000_0100);
        step();
        chk_db("R7 enter auth", dbw(8'h00, 4'h1, 4'd4, 1'b0));
        wr(DB, 32'h0000_0200);
        step();
        chk_db("R7 abort in auth ignored", dbw(8'h00, 4'h2, 4'd4, 1'b0));
        auth_done = 1'b1; auth_pass = 1'b0; auth_code = 32'd0;
        step();
        auth_done = 1'b0;
        chk_db("R10 auth fail zero code", dbw(8'h02, 4'h0, 4'd0, 1'b0));
        chk_ar("R10 zero code maps to 1", 32'd1);

        // R6 both fail flags: erase fail wins
        run_flow(1'b1, 1'b1, 1'b0, 1'b1, 32'd0, 1'b1);
        run_flow(1'b0, 1'b1, 1'b0, 1'b1, 32'd0, 1'b1);
        // R8 abort
        run_flow(1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 1'b1);
        // R10 with a code, R9 copy failure
        run_flow(1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_00A5, 1'b1);
        run_flow(1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b0);

        // Random flows
        for (int i = 0; i < 40; i++) begin
            bit ef, ew, ab, ap, cp;
            logic [31:0] code;
            ef   = ($urandom % 4) == 0;
            ew   = ($urandom % 4) == 0;
            ab   = ($urandom % 4) == 0;
            ap   = ($urandom % 4) != 0;
            cp   = ($urandom % 4) != 0;
            code = ($urandom % 3 == 0) ? 32'd0 : $urandom;
            run_flow(ef, ew, ab, ap, code, cp);
            rd(DB, d);
            chk("R2 phase at rest", {28'd0, d[7:4]},
                (d[7:4] == 4'd8) ? 32'd8 : 32'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule